// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and checks even parity for a 32-bit multiplexed address/data bus that carries a 4-bit active-low command/byte-enable field beside it. Every clock it folds the address/data and command/byte-enable bits into one parity bit and presents it one clock later. It opens the parity output enable only in the clock after this agent drives the bus, and only in three cases: an address phase it initiates, a write data phase it initiates, or a read data phase it serves as target.

When the agent is the target of a write, each data phase that completes is captured. Completion needs both ready strobes low on the same clock. The parity bit received on the next clock is compared against the captured value. A mismatch drives the active-low parity-error line for one clock, two clocks after the data phase, and sets a sticky status bit. An error reported by another device on the shared error line also sets that bit. Either kind of error can raise a one-clock request on the non-maskable or the system-management interrupt line, chosen by a configuration input.

Top module: `bus_parity_unit`

## Requirements
- R1: After every clock edge, `par_o` equals the XOR of all `ad_i` bits and all `cbe_n_i` bits sampled at that edge, so the ones in those 36 bits plus `par_o` always total an even count. The byte-enable values never remove bits from the sum.
- R2: `par_oe_o` is high in the clock after an edge where `ad_oe_i`=1, `addr_phase_i`=1 and `is_initiator_i`=1.
- R3: `par_oe_o` is high in the clock after an edge where `ad_oe_i`=1, `data_phase_i`=1, and either `is_initiator_i`=1 with `write_i`=1 or `is_target_i`=1 with `write_i`=0.
- R4: `par_oe_o` is low in the clock after any edge where `ad_oe_i`=0, or where the agent is the initiator of a read data phase or the target of a write data phase.
- R5: A data phase is captured for checking when, at an edge, `data_phase_i`=1, `is_target_i`=1, `write_i`=1, `irdy_n_i`=0 and `trdy_n_i`=0. `par_i` sampled at the next edge is then compared with the parity of the captured bits. A matching `par_i` raises no error.
- R6: On a mismatch, `par_err_o`=1, `perr_n_o`=0 and `perr_oe_o`=1 for exactly the clock following the edge after the data phase. In the clock after that, `perr_oe_o` stays 1 with `perr_n_o`=1, and then falls to 0.
- R7: No error is flagged for a phase in which either ready strobe is high, or in which the agent is not the target of a write, whatever value `par_i` has.
- R8: `status_o` resets to 0, is set by a detected error in the same clock as `par_err_o`, and stays set until `status_clr_i`=1 at an edge clears it. A set at the same edge as a clear wins.
- R9: `perr_n_i`=0 sampled at an edge while `perr_oe_o`=0 sets `status_o` from the next clock and counts as an error event.
- R10: When `alarm_en_i`=1, each error event gives a one-clock pulse, in the clock status is set, on `nmi_req_o` if `alarm_sel_i`=0 or on `smi_req_o` if `alarm_sel_i`=1. With `alarm_en_i`=0 both stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | DATA_W | Address/data bus value |
| cbe_n_i | input | CBE_W | Command/byte-enable value (active low) |
| addr_phase_i | input | 1 | Current clock is an address phase |
| data_phase_i | input | 1 | Current clock is a data phase |
| is_initiator_i | input | 1 | Agent is the transaction initiator |
| is_target_i | input | 1 | Agent is the transaction target |
| write_i | input | 1 | 1 = write transaction, 0 = read |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| ad_oe_i | input | 1 | Agent drives the address/data bus this clock |
| par_i | input | 1 | Parity bit received from the bus |
| perr_n_i | input | 1 | Parity-error line as seen on the bus, active low |
| status_clr_i | input | 1 | Write-one-to-clear for the status bit |
| alarm_en_i | input | 1 | Enable interrupt requests on error |
| alarm_sel_i | input | 1 | 0 = non-maskable request, 1 = system-management request |
| par_o | output | 1 | Generated parity, one clock late |
| par_oe_o | output | 1 | Output enable for the parity bit |
| par_err_o | output | 1 | Registered parity mismatch flag |
| perr_n_o | output | 1 | Parity-error drive value, active low |
| perr_oe_o | output | 1 | Output enable for the parity-error line |
| status_o | output | 1 | Sticky parity-error status |
| nmi_req_o | output | 1 | Non-maskable interrupt request pulse |
| smi_req_o | output | 1 | System-management interrupt request pulse |

## Verification
The bench builds the block with its default widths, 32 data bits and 4 command bits. The parity therefore spans the full 36-bit field, and patterns with every byte enable set or cleared show that the enables never mask bits. With these widths the timing can be checked exactly: the one-clock parity delay, the two-clock error delay, and the extra drive-high clock on the error line. The bench also covers the collision where a clear arrives on the same edge as an error.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  typedef enum logic {
    ROUTE_NMI = 1'b0,
    ROUTE_SMI = 1'b1
  } alarm_route_e;

  // Even parity over a data word and its command field
  function automatic logic fold_parity(input logic [63:0] word, input int unsigned used);
    logic acc;
    acc = 1'b0;
    for (int unsigned i = 0; i < 64; i++) begin
      if (i < used) acc = acc ^ word[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/bpu_par_gen.sv
module bpu_par_gen #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CBE_W-1:0]  cbe_n_i,
  input  logic              addr_phase_i,
  input  logic              data_phase_i,
  input  logic              is_initiator_i,
  input  logic              is_target_i,
  input  logic              write_i,
  input  logic              ad_oe_i,
  output logic              par_o,
  output logic              par_oe_o
);
  import bpu_pkg::*;

  localparam int FIELD_W = DATA_W + CBE_W;

  logic par_d, par_q;
  logic oe_d, oe_q;
  logic addr_drive, data_drive;

  always_comb begin
    par_d      = fold_parity(64'({cbe_n_i, ad_i}), FIELD_W);
    addr_drive = addr_phase_i & is_initiator_i;
    data_drive = data_phase_i & ((is_initiator_i & write_i) | (is_target_i & ~write_i));
    oe_d       = ad_oe_i & (addr_drive | data_drive);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_d;
      oe_q  <= oe_d;
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;

endmodule

// File: rtl/bpu_par_chk.sv
module bpu_par_chk #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CBE_W-1:0]  cbe_n_i,
  input  logic              data_phase_i,
  input  logic              is_target_i,
  input  logic              write_i,
  input  logic              irdy_n_i,
  input  logic              trdy_n_i,
  input  logic              par_i,
  output logic              mismatch_o
);
  import bpu_pkg::*;

  localparam int FIELD_W = DATA_W + CBE_W;

  logic cap_d, cap_q;
  logic exp_d, exp_q;
  logic exp_en;

  always_comb begin
    cap_d  = data_phase_i & is_target_i & write_i & ~irdy_n_i & ~trdy_n_i;
    exp_en = cap_d;
    exp_d  = fold_parity(64'({cbe_n_i, ad_i}), FIELD_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      if (exp_en) exp_q <= exp_d;
    end
  end

  // Received parity arrives one clock after the captured phase
  assign mismatch_o = cap_q & (par_i ^ exp_q);

endmodule

// File: rtl/bpu_err_report.sv
module bpu_err_report (
  input  logic clk,
  input  logic rst_n,
  input  logic mismatch_i,
  input  logic perr_n_i,
  input  logic status_clr_i,
  input  logic alarm_en_i,
  input  logic alarm_sel_i,
  output logic par_err_o,
  output logic perr_n_o,
  output logic perr_oe_o,
  output logic status_o,
  output logic nmi_req_o,
  output logic smi_req_o
);
  import bpu_pkg::*;

  logic err_q, hold_q;
  logic stat_d, stat_q, stat_en;
  logic ext_err, event_d;
  logic nmi_d, nmi_q, smi_d, smi_q;
  alarm_route_e route;

  always_comb begin
    route   = alarm_route_e'(alarm_sel_i);
    ext_err = ~perr_n_i & ~perr_oe_o;
    event_d = mismatch_i | ext_err;
    stat_en = event_d | status_clr_i;
    stat_d  = event_d;
    nmi_d   = event_d & alarm_en_i & (route == ROUTE_NMI);
    smi_d   = event_d & alarm_en_i & (route == ROUTE_SMI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      hold_q <= 1'b0;
      stat_q <= 1'b0;
      nmi_q  <= 1'b0;
      smi_q  <= 1'b0;
    end else begin
      err_q  <= mismatch_i;
      hold_q <= err_q;
      if (stat_en) stat_q <= stat_d;
      nmi_q  <= nmi_d;
      smi_q  <= smi_d;
    end
  end

  assign par_err_o = err_q;
  assign perr_n_o  = ~err_q;
  assign perr_oe_o = err_q | hold_q;
  assign status_o  = stat_q;
  assign nmi_req_o = nmi_q;
  assign smi_req_o = smi_q;

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [CBE_W-1:0]  cbe_n_i,
  input  logic              addr_phase_i,
  input  logic              data_phase_i,
  input  logic              is_initiator_i,
  input  logic              is_target_i,
  input  logic              write_i,
  input  logic              irdy_n_i,
  input  logic              trdy_n_i,
  input  logic              ad_oe_i,
  input  logic              par_i,
  input  logic              perr_n_i,
  input  logic              status_clr_i,
  input  logic              alarm_en_i,
  input  logic              alarm_sel_i,
  output logic              par_o,
  output logic              par_oe_o,
  output logic              par_err_o,
  output logic              perr_n_o,
  output logic              perr_oe_o,
  output logic              status_o,
  output logic              nmi_req_o,
  output logic              smi_req_o
);

  logic mismatch;

  bpu_par_gen #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_gen (
    .clk            (clk),
    .rst_n          (rst_n),
    .ad_i           (ad_i),
    .cbe_n_i        (cbe_n_i),
    .addr_phase_i   (addr_phase_i),
    .data_phase_i   (data_phase_i),
    .is_initiator_i (is_initiator_i),
    .is_target_i    (is_target_i),
    .write_i        (write_i),
    .ad_oe_i        (ad_oe_i),
    .par_o          (par_o),
    .par_oe_o       (par_oe_o)
  );

  bpu_par_chk #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ad_i         (ad_i),
    .cbe_n_i      (cbe_n_i),
    .data_phase_i (data_phase_i),
    .is_target_i  (is_target_i),
    .write_i      (write_i),
    .irdy_n_i     (irdy_n_i),
    .trdy_n_i     (trdy_n_i),
    .par_i        (par_i),
    .mismatch_o   (mismatch)
  );

  bpu_err_report u_rpt (
    .clk          (clk),
    .rst_n        (rst_n),
    .mismatch_i   (mismatch),
    .perr_n_i     (perr_n_i),
    .status_clr_i (status_clr_i),
    .alarm_en_i   (alarm_en_i),
    .alarm_sel_i  (alarm_sel_i),
    .par_err_o    (par_err_o),
    .perr_n_o     (perr_n_o),
    .perr_oe_o    (perr_oe_o),
    .status_o     (status_o),
    .nmi_req_o    (nmi_req_o),
    .smi_req_o    (smi_req_o)
  );

endmodule

// File: rtl/bpu_checker.sv
module bpu_checker #(
  parameter int DATA_W = 32,
  parameter int CBE_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ad_i,
  input logic [CBE_W-1:0]  cbe_n_i,
  input logic              data_phase_i,
  input logic              is_target_i,
  input logic              write_i,
  input logic              irdy_n_i,
  input logic              trdy_n_i,
  input logic              ad_oe_i,
  input logic              status_clr_i,
  input logic              alarm_en_i,
  input logic              par_o,
  input logic              par_oe_o,
  input logic              perr_n_o,
  input logic              perr_oe_o,
  input logic              status_o,
  input logic              nmi_req_o,
  input logic              smi_req_o
);

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (par_o == ^$past({cbe_n_i, ad_i}))); // R1

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe_i |=> !par_oe_o); // R4

  AST_PERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(data_phase_i & is_target_i & write_i & !irdy_n_i & !trdy_n_i, 2)); // R6

  AST_PERR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> perr_oe_o); // R6

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status_o && !status_clr_i |=> status_o); // R8

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_req_o, smi_req_o})); // R10

  AST_REQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en_i |=> !nmi_req_o && !smi_req_o); // R10

endmodule

bind bus_parity_unit bpu_checker #(.DATA_W(DATA_W), .CBE_W(CBE_W)) u_bpu_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .ad_i         (ad_i),
  .cbe_n_i      (cbe_n_i),
  .data_phase_i (data_phase_i),
  .is_target_i  (is_target_i),
  .write_i      (write_i),
  .irdy_n_i     (irdy_n_i),
  .trdy_n_i     (trdy_n_i),
  .ad_oe_i      (ad_oe_i),
  .status_clr_i (status_clr_i),
  .alarm_en_i   (alarm_en_i),
  .par_o        (par_o),
  .par_oe_o     (par_oe_o),
  .perr_n_o     (perr_n_o),
  .perr_oe_o    (perr_oe_o),
  .status_o     (status_o),
  .nmi_req_o    (nmi_req_o),
  .smi_req_o    (smi_req_o)
);

// File: tb/tb_bus_parity_unit.sv
`timescale 1ns/1ps
module tb_bus_parity_unit;

  logic        clk, rst_n;
  logic [31:0] ad;
  logic [3:0]  cbe_n;
  logic addr_ph, data_ph, init, targ, wr, irdy_n, trdy_n, ad_oe, par_in, perr_in;
  logic clr, a_en, a_sel;
  logic par_o, par_oe, par_err, perr_n_o, perr_oe, status, nmi, smi;

  int n_chk, n_fail;
  bit done;

  bus_parity_unit dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n),
    .addr_phase_i(addr_ph), .data_phase_i(data_ph), .is_initiator_i(init),
    .is_target_i(targ), .write_i(wr), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
    .ad_oe_i(ad_oe), .par_i(par_in), .perr_n_i(perr_in), .status_clr_i(clr),
    .alarm_en_i(a_en), .alarm_sel_i(a_sel),
    .par_o(par_o), .par_oe_o(par_oe), .par_err_o(par_err), .perr_n_o(perr_n_o),
    .perr_oe_o(perr_oe), .status_o(status), .nmi_req_o(nmi), .smi_req_o(smi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    addr_ph = 0; data_ph = 0; init = 0; targ = 0; wr = 0;
    irdy_n = 1; trdy_n = 1; ad_oe = 0; par_in = 0; perr_in = 1; clr = 0;
  endtask

  function automatic logic model_par(input logic [31:0] a, input logic [3:0] c);
    int ones = 0;
    for (int i = 0; i < 32; i++) ones += a[i];
    for (int i = 0; i < 4; i++) ones += c[i];
    return ones[0];
  endfunction

  // Target write data phase; bad selects a wrong received parity
  task automatic tgt_write(input logic [31:0] a, input logic [3:0] c, input bit bad,
                           input bit complete);
    idle();
    data_ph = 1; targ = 1; wr = 1; ad = a; cbe_n = c;
    irdy_n = 0; trdy_n = complete ? 1'b0 : 1'b1;
    tick();
    idle();
    par_in = model_par(a, c) ^ bad;
    tick();
  endtask

  task automatic t_reset();
    check("R8 reset status", status, 0);
    check("R4 reset par_oe", par_oe, 0);
    check("R6 reset perr_n", perr_n_o, 1);
    check("R6 reset perr_oe", perr_oe, 0);
    check("R10 reset req", {nmi, smi}, 0);
  endtask

  task automatic t_generate();
    for (int k = 0; k < 6; k++) begin
      idle();
      ad = 32'h9E3779B1 * (k + 3);
      cbe_n = (k % 2 == 0) ? 4'hF : 4'h0;
      if (k == 5) ad = 32'hFFFF_FFFF;
      addr_ph = 1; init = 1; ad_oe = 1;
      tick();
      check("R1 parity value", par_o, model_par(ad, cbe_n));
      check("R2 addr phase oe", par_oe, 1);
    end
  endtask

  task automatic t_roles();
    idle(); ad = 32'h1234_5678; cbe_n = 4'h3;
    data_ph = 1; init = 1; wr = 1; ad_oe = 1; tick();
    check("R3 initiator write oe", par_oe, 1);
    idle(); data_ph = 1; targ = 1; wr = 0; ad_oe = 1; tick();
    check("R3 target read oe", par_oe, 1);
    idle(); data_ph = 1; init = 1; wr = 0; ad_oe = 1; tick();
    check("R4 initiator read oe", par_oe, 0);
    idle(); data_ph = 1; targ = 1; wr = 1; ad_oe = 1; tick();
    check("R4 target write oe", par_oe, 0);
    idle(); addr_ph = 1; init = 1; ad_oe = 0; tick();
    check("R4 no ad_oe", par_oe, 0);
    idle(); tick();
  endtask

  task automatic t_check_good();
    tgt_write(32'hCAFE_0001, 4'h5, 0, 1);
    check("R5 good parity err", par_err, 0);
    check("R5 good parity perr_n", perr_n_o, 1);
    check("R5 good parity status", status, 0);
  endtask

  task automatic t_check_bad();
    a_en = 1; a_sel = 0;
    tgt_write(32'h0F0F_1234, 4'hA, 1, 1);
    check("R6 err flag", par_err, 1);
    check("R6 perr_n low", perr_n_o, 0);
    check("R6 perr_oe", perr_oe, 1);
    check("R8 status set", status, 1);
    check("R10 nmi pulse", {nmi, smi}, 2'b10);
    tick();
    check("R6 perr_n released", perr_n_o, 1);
    check("R6 perr_oe hold", perr_oe, 1);
    check("R10 pulse ends", {nmi, smi}, 0);
    check("R8 sticky", status, 1);
    tick();
    check("R6 perr_oe off", perr_oe, 0);
    clr = 1; tick(); idle();
    check("R8 cleared", status, 0);
  endtask

  task automatic t_ignored();
    tgt_write(32'h5555_AAAA, 4'h1, 1, 0);
    check("R7 incomplete no err", par_err, 0);
    idle(); data_ph = 1; init = 1; wr = 1; irdy_n = 0; trdy_n = 0;
    ad = 32'h7; cbe_n = 4'h0; tick();
    idle(); par_in = ~model_par(32'h7, 4'h0); tick();
    check("R7 initiator write no err", par_err, 0);
    check("R7 status untouched", status, 0);
  endtask

  task automatic t_set_wins();
    a_en = 0;
    idle(); data_ph = 1; targ = 1; wr = 1; irdy_n = 0; trdy_n = 0;
    ad = 32'hDEAD_BEEF; cbe_n = 4'hC; tick();
    idle(); par_in = ~model_par(32'hDEAD_BEEF, 4'hC); clr = 1; tick(); idle();
    check("R8 set beats clear", status, 1);
    check("R10 masked", {nmi, smi}, 0);
    tick(); tick();
    clr = 1; tick(); idle();
    check("R8 clear", status, 0);
  endtask

  task automatic t_external();
    a_en = 1; a_sel = 1;
    idle(); perr_in = 0; tick(); idle();
    check("R9 ext status", status, 1);
    check("R10 smi pulse", {nmi, smi}, 2'b01);
    clr = 1; tick(); idle();
    check("R9 cleared", status, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0;
    idle(); ad = 0; cbe_n = 0; a_en = 0; a_sel = 0;
    rst_n = 0;
    #20 rst_n = 1;
    tick();
    t_reset();
    t_generate();
    t_roles();
    t_check_good();
    t_check_bad();
    t_ignored();
    t_set_wins();
    t_external();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule